// File: doc/BRIEF.md
# SPI Serial Port with Sticky Event Flags

This block is a byte-wide SPI engine that can act as bus master or as slave. Software reaches it through a small register bus with three registers: a control/status register, a data register and a configuration register. Writing the data register fills a one-byte transmit holding buffer. The shift engine takes the byte from that buffer when it is free. A completed byte lands in a receive buffer, and reading the data register returns that byte.

Four event flags are sticky: transfer done, write collision, mode fault and receive overrun. Each one stays set until software writes 0 to it, and any of them raises the interrupt line while interrupts are enabled. A two-bit select-mode field chooses how the slave-select pin is used: ignored (3-wire), a select/fault input (4-wire slave or multi-master), or an output that copies the low mode bit (4-wire single master). Master timing is SPI mode 0 (SCK idles low, data is sampled on the rising edge) and data goes MSB first. The SCK half period is a fixed number of system clocks. In slave mode the block synchronises SCK and MOSI into the system clock before it detects edges.

Register map. Address 0 is control/status: bit0 port on, bit1 transmit-buffer-empty (read only), bits3:2 select mode, bit4 done, bit5 collision, bit6 fault, bit7 overrun. Address 1 is data. Address 2 is configuration: bit0 master, bit1 interrupt enable.

Top module: `spi_port`

## Requirements
- R1: After reset, address 0 reads 0x06 (select mode 01, transmit buffer empty, everything else 0), address 2 reads 0x00, and irq and all output enables are 0.
- R2: The transmit-buffer-empty bit (address 0 bit1) goes to 0 when a data write is accepted, and returns to 1 once the engine takes the byte. Writes to this bit have no effect.
- R3: A data write while bit1 is 0 sets the collision flag (bit5), and the transmit buffer keeps its earlier byte.
- R4: In master mode the byte is shifted MSB first with SCK idle low. MISO is sampled on rising SCK and MOSI changes on falling SCK. At the end of the byte the received value is placed in the receive buffer and the done flag (bit4) is set.
- R5: In slave mode a byte clocked in on SCK/MOSI is received MSB first, and the transmit byte is presented on MISO MSB first. The done flag is set after the eighth rising edge.
- R6: The overrun flag (bit7) is set only in slave mode, when a byte completes while the previous one is still unread. The receive buffer then keeps the unread byte. In master mode a new byte overwrites the buffer and no overrun is raised.
- R7: With master mode on, select mode 01 and the select input low, the fault flag (bit6) is set, the master bit (address 2 bit0) is cleared, SCK/MOSI drive stops, and a transfer in progress is dropped without setting done.
- R8: Select mode 00 makes the slave always selected. Select mode 1x drives the select pin as an output with the value of mode bit 0. Select mode 01 leaves that pin undriven.
- R9: irq is 1 exactly when interrupts are enabled and at least one of the four flags is set. Flags stay set until software writes 0 to them.
- R10: With the port-on bit at 0, no pin is driven and SCK activity produces no transfer.
- R11: In select mode 01 as slave with the select input high, MISO is not driven and SCK edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Register access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| sckIn | input | 1 | Serial clock from external master |
| sckOut | output | 1 | Serial clock in master mode |
| sckOe | output | 1 | Drive enable for sckOut |
| mosiIn | input | 1 | Serial data in (slave) |
| mosiOut | output | 1 | Serial data out (master) |
| mosiOe | output | 1 | Drive enable for mosiOut |
| misoIn | input | 1 | Serial data in (master) |
| misoOut | output | 1 | Serial data out (slave) |
| misoOe | output | 1 | Drive enable for misoOut |
| nssIn | input | 1 | Slave-select input |
| nssOut | output | 1 | Slave-select output value |
| nssOe | output | 1 | Drive enable for nssOut |

## Verification
The hardest case to reach is a mode fault that lands in the middle of a master byte. The stimulus enables master mode with the select input high, starts a byte, and waits about twenty cycles so that SCK is toggling. It then pulls the select input low, and the bench confirms that the byte never completes and that SCK drive is gone. The collision case is built with the port switched off: the first byte then stays parked in the buffer, a second write is guaranteed to collide, and enabling the port afterwards shows which byte actually went out on MOSI.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;

  typedef enum logic [1:0] {
    SEL_THREE_WIRE = 2'b00,
    SEL_MULTI      = 2'b01,
    SEL_DRIVE_LO   = 2'b10,
    SEL_DRIVE_HI   = 2'b11
  } selMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic enable;
    logic master;
    logic txFull;
    logic slaveSel;
    logic abort;
  } spiCmd_t;

  // datapath -> control events
  typedef struct packed {
    logic taken;
    logic done;
  } spiEvt_t;

endpackage

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int SCK_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiCmd_t           cmd,
  input  logic [DATA_W-1:0] txByte,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  output spiEvt_t           evt,
  output logic [DATA_W-1:0] rxByte,
  output logic              sckOut,
  output logic              shMsb
);

  localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sckSync;
  logic [SYNC_STAGES-1:0] mosiSync;
  logic                   sckPrev;
  logic                   sckRise;
  logic                   sckFall;
  logic                   mosiS;

  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  bitCnt;
  logic [DIV_W-1:0]  divCnt;
  logic              busy;
  logic              sckR;
  logic              sampled;
  logic              takenQ;
  logic              doneQ;
  logic [DATA_W-1:0] rxQ;

  // input synchronisers for slave mode
  generate
    if (SYNC_STAGES > 1) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckSync  <= '0;
          mosiSync <= '0;
        end else begin
          sckSync  <= {sckSync[SYNC_STAGES-2:0], sckIn};
          mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
        end
      end
    end else begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckSync  <= '0;
          mosiSync <= '0;
        end else begin
          sckSync  <= sckIn;
          mosiSync <= mosiIn;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckSync[SYNC_STAGES-1];
  end

  assign sckRise = sckSync[SYNC_STAGES-1] & ~sckPrev;
  assign sckFall = ~sckSync[SYNC_STAGES-1] & sckPrev;
  assign mosiS   = mosiSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sh      <= '0;
      bitCnt  <= '0;
      divCnt  <= '0;
      busy    <= 1'b0;
      sckR    <= 1'b0;
      sampled <= 1'b0;
      takenQ  <= 1'b0;
      doneQ   <= 1'b0;
      rxQ     <= '0;
    end else begin
      takenQ <= 1'b0;
      doneQ  <= 1'b0;
      if (!cmd.enable || cmd.abort) begin
        busy   <= 1'b0;
        sckR   <= 1'b0;
        bitCnt <= '0;
        divCnt <= '0;
      end else if (cmd.master) begin
        if (!busy) begin
          sckR   <= 1'b0;
          bitCnt <= '0;
          divCnt <= '0;
          if (cmd.txFull) begin
            sh     <= txByte;
            busy   <= 1'b1;
            takenQ <= 1'b1;
          end
        end else if (divCnt == DIV_LAST) begin
          divCnt <= '0;
          if (!sckR) begin
            sckR    <= 1'b1;
            sampled <= misoIn;
          end else begin
            sckR <= 1'b0;
            sh   <= {sh[DATA_W-2:0], sampled};
            if (bitCnt == BIT_LAST) begin
              busy   <= 1'b0;
              doneQ  <= 1'b1;
              rxQ    <= {sh[DATA_W-2:0], sampled};
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end else begin
        busy <= 1'b0;
        sckR <= 1'b0;
        if (!cmd.slaveSel) begin
          bitCnt <= '0;
          if (cmd.txFull) begin
            sh     <= txByte;
            takenQ <= 1'b1;
          end
        end else if (sckRise) begin
          sampled <= mosiS;
          if (bitCnt == BIT_LAST) begin
            doneQ  <= 1'b1;
            rxQ    <= {sh[DATA_W-2:0], mosiS};
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end else if (sckFall && bitCnt != '0) begin
          sh <= {sh[DATA_W-2:0], sampled};
        end else if (bitCnt == '0 && cmd.txFull) begin
          sh     <= txByte;
          takenQ <= 1'b1;
        end
      end
    end
  end

  assign evt.taken = takenQ;
  assign evt.done  = doneQ;
  assign rxByte    = rxQ;
  assign sckOut    = sckR;
  assign shMsb     = sh[DATA_W-1];

  // R10
  off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.enable |=> (!busy && !sckR));

  // R4
  sck_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    sckR |-> busy);

endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  spiEvt_t           evt,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              nssIn,
  output spiCmd_t           cmd,
  output logic [DATA_W-1:0] txByte,
  output logic              irq,
  output logic              sckOe,
  output logic              mosiOe,
  output logic              misoOe,
  output logic              nssOut,
  output logic              nssOe
);

  logic             onBit;
  selMode_e         selMode;
  logic             txEmpty;
  logic [DATA_W-1:0] txBuf;
  logic [DATA_W-1:0] rxBuf;
  logic             rxFull;
  logic             doneF;
  logic             colF;
  logic             faultF;
  logic             ovrF;
  logic             masterBit;
  logic             irqEn;
  logic [SYNC_STAGES-1:0] nssSync;
  logic             nssS;

  logic wrCtrl;
  logic wrData;
  logic wrCfg;
  logic rdData;
  logic collide;
  logic faultNow;
  logic ovrSet;
  logic slaveSel;

  assign wrCtrl = busEn & busWe & (busAddr == ADDR_CTRL);
  assign wrData = busEn & busWe & (busAddr == ADDR_DATA);
  assign wrCfg  = busEn & busWe & (busAddr == ADDR_CFG);
  assign rdData = busEn & ~busWe & (busAddr == ADDR_DATA);

  generate
    if (SYNC_STAGES > 1) begin : g_nss
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) nssSync <= '1;
        else       nssSync <= {nssSync[SYNC_STAGES-2:0], nssIn};
      end
    end else begin : g_nss1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) nssSync <= '1;
        else       nssSync <= nssIn;
      end
    end
  endgenerate
  assign nssS = nssSync[SYNC_STAGES-1];

  assign collide  = wrData & ~txEmpty;
  assign faultNow = onBit & masterBit & (selMode == SEL_MULTI) & ~nssS;
  assign ovrSet   = evt.done & rxFull & ~masterBit;
  assign slaveSel = (selMode != SEL_MULTI) | ~nssS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onBit     <= 1'b0;
      selMode   <= SEL_MULTI;
      txEmpty   <= 1'b1;
      txBuf     <= '0;
      rxBuf     <= '0;
      rxFull    <= 1'b0;
      doneF     <= 1'b0;
      colF      <= 1'b0;
      faultF    <= 1'b0;
      ovrF      <= 1'b0;
      masterBit <= 1'b0;
      irqEn     <= 1'b0;
    end else begin
      if (wrCtrl) begin
        onBit   <= busWdata[0];
        selMode <= selMode_e'(busWdata[3:2]);
      end

      if (evt.taken) txEmpty <= 1'b1;
      if (wrData && txEmpty) begin
        txEmpty <= 1'b0;
        txBuf   <= busWdata;
      end

      doneF  <= evt.done | (wrCtrl ? busWdata[4] : doneF);
      colF   <= collide  | (wrCtrl ? busWdata[5] : colF);
      faultF <= faultNow | (wrCtrl ? busWdata[6] : faultF);
      ovrF   <= ovrSet   | (wrCtrl ? busWdata[7] : ovrF);

      if (evt.done) begin
        if (!ovrSet) rxBuf <= rxByte;
        rxFull <= 1'b1;
      end else if (rdData) begin
        rxFull <= 1'b0;
      end

      if (wrCfg) begin
        masterBit <= busWdata[0];
        irqEn     <= busWdata[1];
      end
      if (faultNow) masterBit <= 1'b0;
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL: busRdata = {ovrF, faultF, colF, doneF, selMode, txEmpty, onBit};
      ADDR_DATA: busRdata = rxBuf;
      ADDR_CFG:  busRdata = {{(DATA_W-2){1'b0}}, irqEn, masterBit};
      default:   busRdata = '0;
    endcase
  end

  assign cmd.enable   = onBit;
  assign cmd.master   = masterBit;
  assign cmd.txFull   = ~txEmpty;
  assign cmd.slaveSel = slaveSel;
  assign cmd.abort    = faultNow;
  assign txByte       = txBuf;

  assign irq    = irqEn & (doneF | colF | faultF | ovrF);
  assign sckOe  = onBit & masterBit;
  assign mosiOe = onBit & masterBit;
  assign misoOe = onBit & ~masterBit & slaveSel;
  assign nssOe  = onBit & selMode[1];
  assign nssOut = selMode[0];

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneF) |-> $past(wrCtrl));

  // R3
  wcol_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    collide |=> $stable(txBuf));

  // R2
  load_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.taken |=> txEmpty);

  // R7
  fault_master_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultF) |-> !masterBit);

  // R6
  ovr_slave_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ovrF) && !$past(wrCtrl)) |-> !$past(masterBit));

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int SCK_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busEn,
  input  logic       busWe,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irq,
  input  logic       sckIn,
  output logic       sckOut,
  output logic       sckOe,
  input  logic       mosiIn,
  output logic       mosiOut,
  output logic       mosiOe,
  input  logic       misoIn,
  output logic       misoOut,
  output logic       misoOe,
  input  logic       nssIn,
  output logic       nssOut,
  output logic       nssOe
);

  spiCmd_t           cmd;
  spiEvt_t           evt;
  logic [DATA_W-1:0] txByte;
  logic [DATA_W-1:0] rxByte;
  logic              shMsb;

  spi_port_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busEn    (busEn),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .evt      (evt),
    .rxByte   (rxByte),
    .nssIn    (nssIn),
    .cmd      (cmd),
    .txByte   (txByte),
    .irq      (irq),
    .sckOe    (sckOe),
    .mosiOe   (mosiOe),
    .misoOe   (misoOe),
    .nssOut   (nssOut),
    .nssOe    (nssOe)
  );

  spi_port_dp #(.SCK_HALF(SCK_HALF), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .txByte (txByte),
    .sckIn  (sckIn),
    .mosiIn (mosiIn),
    .misoIn (misoIn),
    .evt    (evt),
    .rxByte (rxByte),
    .sckOut (sckOut),
    .shMsb  (shMsb)
  );

  assign mosiOut = shMsb;
  assign misoOut = shMsb;

endmodule

// File: tb/spi_port_tb.sv
`timescale 1ns/1ps
module spi_port_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busEn = 1'b0;
  logic       busWe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       irq;
  logic       sckIn = 1'b0;
  logic       sckOut;
  logic       sckOe;
  logic       mosiIn = 1'b0;
  logic       mosiOut;
  logic       mosiOe;
  logic       misoIn = 1'b0;
  logic       misoOut;
  logic       misoOe;
  logic       nssIn = 1'b1;
  logic       nssOut;
  logic       nssOe;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  spi_port u_dut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe),
    .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe),
    .nssIn(nssIn), .nssOut(nssOut), .nssOe(nssOe)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busEn = 1'b0; busWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // external slave model for master-mode bytes
  task automatic masterRun(input logic [7:0] slv, output logic [7:0] got);
    misoIn = slv[7];
    for (int i = 0; i < 8; i++) begin
      @(posedge sckOut);
      got = {got[6:0], mosiOut};
      @(negedge sckOut);
      if (i < 7) misoIn = slv[6-i];
    end
    idle(10);
  endtask

  // external master model for slave-mode bytes
  task automatic slaveByte(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      mosiIn = mo[i];
      idle(8);
      mi[i] = misoOut;
      sckIn = 1'b1;
      idle(8);
      sckIn = 1'b0;
    end
    idle(20);
  endtask

  task automatic testReset();
    logic [7:0] v;
    rd(2'd0, v); check(v, 8'h06, "R1 ctrl reset");
    rd(2'd2, v); check(v, 8'h00, "R1 cfg reset");
    check({3'b0, sckOe, mosiOe, misoOe, nssOe, irq}, 8'h00, "R1 pins/irq reset");
    wr(2'd0, 8'h04);
    rd(2'd0, v); check(v, 8'h06, "R2 empty bit read-only");
  endtask

  task automatic testNssModes();
    wr(2'd0, 8'h0D);
    idle(1); check({6'b0, nssOe, nssOut}, 8'h03, "R8 mode 11 drives high");
    wr(2'd0, 8'h09);
    idle(1); check({6'b0, nssOe, nssOut}, 8'h02, "R8 mode 10 drives low");
    wr(2'd0, 8'h05);
    idle(1); check({7'b0, nssOe}, 8'h00, "R8 mode 01 not driven");
    wr(2'd0, 8'h04);
  endtask

  task automatic testCollisionAndMaster();
    logic [7:0] v;
    logic [7:0] got;
    wr(2'd1, 8'h11);
    rd(2'd0, v); check(v, 8'h04, "R2 empty cleared by write");
    wr(2'd1, 8'h22);
    rd(2'd0, v); check(v, 8'h24, "R3 collision flag");
    wr(2'd0, 8'h04);
    rd(2'd0, v); check(v, 8'h04, "R9 collision cleared by 0");
    wr(2'd2, 8'h03);
    nssIn = 1'b1;
    wr(2'd0, 8'h05);
    masterRun(8'h3C, got);
    check(got, 8'h11, "R3 kept first byte / R4 MOSI MSB first");
    rd(2'd0, v); check(v, 8'h17, "R4 done flag, R2 empty again");
    check({7'b0, irq}, 8'h01, "R9 irq on done");
    rd(2'd1, v); check(v, 8'h3C, "R4 MISO byte received");
    wr(2'd2, 8'h01);
    idle(1); check({7'b0, irq}, 8'h00, "R9 irq masked");
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h05);
    idle(1); check({7'b0, irq}, 8'h00, "R9 irq low after clear");
    // two master bytes, none read: newest kept, no overrun
    wr(2'd1, 8'hE7);
    masterRun(8'h81, got);
    check(got, 8'hE7, "R4 second byte MOSI");
    wr(2'd1, 8'h42);
    masterRun(8'h99, got);
    rd(2'd0, v); check(v, 8'h17, "R6 no overrun in master");
    rd(2'd1, v); check(v, 8'h99, "R6 master overwrites buffer");
    wr(2'd0, 8'h05);
  endtask

  task automatic testFault();
    logic [7:0] v;
    wr(2'd1, 8'h55);
    idle(20);
    nssIn = 1'b0;
    idle(10);
    rd(2'd0, v); check(v, 8'h47, "R7 fault flag, no done");
    rd(2'd2, v); check(v, 8'h02, "R7 master bit cleared");
    check({6'b0, sckOe, mosiOe}, 8'h00, "R7 drive dropped");
    check({7'b0, irq}, 8'h01, "R9 irq on fault");
    idle(100);
    rd(2'd0, v); check(v, 8'h47, "R7 aborted byte never completes");
    nssIn = 1'b1;
    wr(2'd0, 8'h05);
  endtask

  task automatic testSlave();
    logic [7:0] v;
    logic [7:0] mi;
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h5A);
    nssIn = 1'b0;
    idle(4);
    check({7'b0, misoOe}, 8'h01, "R5 MISO driven when selected");
    slaveByte(8'hC3, mi);
    check(mi, 8'h5A, "R5 MISO byte");
    rd(2'd0, v); check(v, 8'h17, "R5 done flag");
    slaveByte(8'h0F, mi);
    rd(2'd0, v); check(v, 8'h97, "R6 overrun flag");
    rd(2'd1, v); check(v, 8'hC3, "R6 unread byte kept");
    wr(2'd0, 8'h05);
    nssIn = 1'b1;
    idle(4);
    check({7'b0, misoOe}, 8'h00, "R11 MISO off when deselected");
    slaveByte(8'hFF, mi);
    rd(2'd0, v); check(v, 8'h07, "R11 deselected edges ignored");
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h96);
    slaveByte(8'h3A, mi);
    check(mi, 8'h96, "R8 3-wire MISO byte");
    rd(2'd0, v); check(v, 8'h13, "R8 3-wire done");
    rd(2'd1, v); check(v, 8'h3A, "R8 3-wire receive");
  endtask

  task automatic testDisabled();
    logic [7:0] v;
    logic [7:0] mi;
    wr(2'd0, 8'h00);
    idle(2);
    check({4'b0, sckOe, mosiOe, misoOe, nssOe}, 8'h00, "R10 no pin driven");
    slaveByte(8'h77, mi);
    rd(2'd0, v); check(v, 8'h02, "R10 no transfer when off");
  endtask

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(3);
    testReset();
    testNssModes();
    testCollisionAndMaster();
    testFault();
    testSlave();
    testDisabled();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #750000;
    vectors++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule